// File: doc/BRIEF.md
# Output Gating and Protection Controller

This block decides the final on/off state of eight power output drivers. It takes the command word last latched from the serial control path and two direct pulse-width inputs. It also takes a set of supervisory flags from analog comparators: enable, logic supply present, supply undervoltage, supply overvoltage, and one overtemperature flag per output. From these it produces the drive for each output and the enable for each output's off-state load-detect current. All asynchronous pins pass through a synchronizer before use.

The command register lives here. It is loaded from a parallel word whenever the serial interface signals a completed frame. When the device is asleep (enable low, logic supply absent, or undervoltage), every output and detect current is off and the command register returns to its reset value. On waking, a power-on delay counter runs. While it runs, a busy signal blocks the serial interface and any load attempt is discarded. Overvoltage and overtemperature only mask the drive. The commanded state is kept, so outputs come back without intervention once the flag clears.

Top module: `ogc_top`

## Requirements
- R1: After synchronous reset, drive_o and detect_en_o are all zero and spi_busy_o is 1.
- R2: With the device awake and no fault flags, bit i (0..7) of the latched command word turns drive_o[i] on when 1 and off when 0.
- R3: While awake, bit 8+i of the latched command word appears on detect_en_o[i].
- R4: drive_o[4] is the OR of command bit 4 and pwm_a_i, and drive_o[5] is the OR of command bit 5 and pwm_b_i. Neither direct input affects any other output.
- R5: When the device leaves sleep, spi_busy_o stays 1 for POR_CYCLES clock cycles after the synchronized wake condition. A cmd_load_i pulse while spi_busy_o is 1 leaves the command register unchanged.
- R6: With en_i low or vdd_ok_i low, all drives and detect enables are 0 and the command register is cleared, so the outputs stay off after waking until a new word is loaded.
- R7: uv_flag_i high acts as sleep: all drives and detect enables are forced off and the command register is cleared.
- R8: ov_flag_i high forces every drive off without changing detect_en_o or the command register. When it clears, the drives return to the commanded state.
- R9: ot_flag_i[i] high turns off only drive_o[i]. When it clears, the output turns back on unless its command bit was cleared in the meantime.
- R10: Each pin input passes a two-stage synchronizer and drive_o is registered. A change on a flag or direct input that is applied between clock edges reaches drive_o at the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Device enable; low means sleep |
| vdd_ok_i | input | 1 | Logic supply present flag |
| uv_flag_i | input | 1 | Supply undervoltage flag |
| ov_flag_i | input | 1 | Supply overvoltage flag |
| ot_flag_i | input | 8 | Per-output overtemperature flags |
| pwm_a_i | input | 1 | Direct control input ORed into output index 4 |
| pwm_b_i | input | 1 | Direct control input ORed into output index 5 |
| cmd_load_i | input | 1 | One-cycle pulse: latch cmd_word_i |
| cmd_word_i | input | 16 | Bits 7:0 output commands, bits 15:8 detect-current enables |
| drive_o | output | 8 | Final on/off drive per output |
| detect_en_o | output | 8 | Off-state load-detect current enable per output |
| spi_busy_o | output | 1 | High while asleep or during the power-on delay |

## Verification
The drive function is exercised with random command words combined with random direct-input levels, random overtemperature masks and an overvoltage flag raised about one time in four. Each pattern is checked against a bench model of the gating, which separates command-driven bits from direct-input bits and masked bits. Directed sequences cover behaviour that a single steady-state comparison cannot show. One sequence shows that a flag clearing restores the old command while a command changed during the flag is not overridden. Others show that sleep and undervoltage wipe the register while overvoltage does not, that a load during the power-on delay is lost, and the exact edge at which a flag change reaches the drive.

// File: rtl/ogc_pkg.sv
// Package: shared constants and the bundle of pin-level inputs that are
// synchronized together before the gating logic sees them.
package ogc_pkg;
    localparam int NUM_OUT = 8;
    localparam int CMD_W   = 2 * NUM_OUT;

    typedef struct packed {
        logic               pwm_b;
        logic               pwm_a;
        logic [NUM_OUT-1:0] ot;
        logic               ov;
        logic               uv;
        logic               vdd_ok;
        logic               en;
    } sup_t;

    localparam int SUP_W = $bits(sup_t);
endpackage

// File: rtl/ogc_sync.sv
// Module: ogc_sync
// Multi-stage flop synchronizer for a bundle of independent asynchronous
// bits. Assumes each bit is a level that may be sampled on its own (no
// multi-bit coherency is needed). Reset value of every stage is zero.
module ogc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw pins in the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d_i;
            end
        end else begin : g_rest
            // Pass the value down the chain one stage per edge.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ogc_por.sv
// Module: ogc_por
// Power-on delay timer. While the device sleeps the counter is held at its
// full value. After the wake condition appears it counts down once per
// clock. Busy is high while asleep or while the count is non-zero.
// Assumes POR_CYCLES >= 1.
module ogc_por #(
    parameter int POR_CYCLES = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    output logic busy_o
);
    localparam int CW = $clog2(POR_CYCLES + 1);
    localparam logic [CW-1:0] CNT_INIT = CW'(POR_CYCLES);

    logic [CW-1:0] cnt_q;

    // Reload on sleep, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep_i)   cnt_q <= CNT_INIT;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = sleep_i || (cnt_q != '0);

    // R5: any sleep cycle leaves the interface blocked on the next cycle.
    p_sleep_rearms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> busy_o);
endmodule

// File: rtl/ogc_cmd_reg.sv
// Module: ogc_cmd_reg
// Command register fed by the serial interface. It loads on a one-cycle
// strobe when the interface is not blocked and clears to the power-on value
// (all zero) whenever the device sleeps. Assumes load_i is a single-cycle
// pulse generated in this clock domain.
module ogc_cmd_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep_i,
    input  logic         busy_i,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] q_o
);
    // Hold, clear on sleep, or take a new word when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep_i)      q_o <= '0;
        else if (load_i && !busy_i) q_o <= word_i;
    end

    // R6/R7: sleep returns the register to its power-on value.
    p_sleep_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (q_o == '0));

    // R5: a blocked interface cannot change the register while awake.
    p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !sleep_i) |=> $stable(q_o));
endmodule

// File: rtl/ogc_top.sv
// Module: ogc_top
// Output gating and protection controller. It synchronizes the pin inputs,
// derives sleep (enable low, supply absent, or undervoltage), runs the
// power-on delay, holds the command register and produces the registered
// drive and detect-current enables. Overvoltage and overtemperature only
// mask the drive, so the commanded state survives them.
// Assumes cmd_load_i/cmd_word_i come from a serial interface in this clock
// domain and that the flag inputs are asynchronous levels.
module ogc_top
    import ogc_pkg::*;
#(
    parameter int POR_CYCLES  = 25000,
    parameter int SYNC_STAGES = 2,
    parameter int PWM_A_IDX   = 4,
    parameter int PWM_B_IDX   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               vdd_ok_i,
    input  logic               uv_flag_i,
    input  logic               ov_flag_i,
    input  logic [NUM_OUT-1:0] ot_flag_i,
    input  logic               pwm_a_i,
    input  logic               pwm_b_i,
    input  logic               cmd_load_i,
    input  logic [CMD_W-1:0]   cmd_word_i,
    output logic [NUM_OUT-1:0] drive_o,
    output logic [NUM_OUT-1:0] detect_en_o,
    output logic               spi_busy_o
);
    sup_t               raw_sup;
    sup_t               s_sup;
    logic               sleep;
    logic               busy;
    logic [CMD_W-1:0]   cmd_q;
    logic [NUM_OUT-1:0] want;

    // Bundle the asynchronous pins for the synchronizer.
    always_comb begin
        raw_sup.pwm_b  = pwm_b_i;
        raw_sup.pwm_a  = pwm_a_i;
        raw_sup.ot     = ot_flag_i;
        raw_sup.ov     = ov_flag_i;
        raw_sup.uv     = uv_flag_i;
        raw_sup.vdd_ok = vdd_ok_i;
        raw_sup.en     = en_i;
    end

    ogc_sync #(.W(SUP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_sup),
        .q_o   (s_sup)
    );

    // Sleep: no enable, no logic supply, or undervoltage reset.
    assign sleep = !s_sup.en || !s_sup.vdd_ok || s_sup.uv;

    ogc_por #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep),
        .busy_o  (busy)
    );

    ogc_cmd_reg #(.W(CMD_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep),
        .busy_i  (busy),
        .load_i  (cmd_load_i),
        .word_i  (cmd_word_i),
        .q_o     (cmd_q)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
        logic direct;
        // Direct input for the two pulse-width channels, zero elsewhere.
        assign direct = (i == PWM_A_IDX) ? s_sup.pwm_a :
                        (i == PWM_B_IDX) ? s_sup.pwm_b : 1'b0;
        // Requested state, masked by sleep, overvoltage and own thermal flag.
        assign want[i] = (cmd_q[i] || direct) && !sleep && !s_sup.ov && !s_sup.ot[i];

        // R9: a hot channel is off on the next edge.
        p_ot_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
            s_sup.ot[i] |=> !drive_o[i]);
    end

    // Register the final drive and detect enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_o     <= '0;
            detect_en_o <= '0;
        end else begin
            drive_o     <= want;
            detect_en_o <= sleep ? '0 : cmd_q[CMD_W-1:NUM_OUT];
        end
    end

    assign spi_busy_o = busy;

    // R8: overvoltage blanks every output one edge later.
    p_ov_all_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_sup.ov |=> (drive_o == '0));

    // R7: undervoltage blanks every output one edge later.
    p_uv_all_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_sup.uv |=> (drive_o == '0));

    // R6: no detect current while asleep.
    p_sleep_no_detect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (detect_en_o == '0));
endmodule

// File: tb/ogc_top_tb_top.sv
// Bench for ogc_top: directed sequences for sleep, power-on delay, latency
// and flag recovery, then seeded random gating patterns checked against a
// bench model.
module ogc_top_tb_top;
    localparam int POR = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, vdd_ok = 1'b0, uv = 1'b0, ov = 1'b0;
    logic [7:0]  ot = '0;
    logic        pwm_a = 1'b0, pwm_b = 1'b0;
    logic        load = 1'b0;
    logic [15:0] word = '0;
    logic [7:0]  drive, detect;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ogc_top #(.POR_CYCLES(POR)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .vdd_ok_i(vdd_ok),
        .uv_flag_i(uv), .ov_flag_i(ov), .ot_flag_i(ot),
        .pwm_a_i(pwm_a), .pwm_b_i(pwm_b), .cmd_load_i(load),
        .cmd_word_i(word), .drive_o(drive), .detect_en_o(detect),
        .spi_busy_o(busy)
    );

    function automatic logic [7:0] model_drive(logic [7:0] c, logic pa, logic pb,
                                               logic [7:0] hot, logic ovf);
        logic [7:0] r = c;
        r[4] = r[4] | pa;
        r[5] = r[5] | pb;
        if (ovf) r = '0;
        return r & ~hot;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(logic [15:0] w);
        @(negedge clk);
        word = w;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        tick(4);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 drive", {8'h0, drive}, 16'h0);
        chk("R1 detect", {8'h0, detect}, 16'h0);
        chk("R1 busy", {15'h0, busy}, 16'h1);

        // R5: power-on delay and blocked load
        en = 1'b1; vdd_ok = 1'b1;
        tick(9);
        send(16'h00FF);
        chk("R5 busy during delay", {15'h0, busy}, 16'h1);
        tick(POR);
        chk("R5 busy released", {15'h0, busy}, 16'h0);
        chk("R5 load during busy ignored", {8'h0, drive}, 16'h0);

        // R2, R3: command bits to drive and detect
        send(16'hA53C); tick(3);
        chk("R2 drive", {8'h0, drive}, 16'h003C);
        chk("R3 detect", {8'h0, detect}, 16'h00A5);

        // R4: direct inputs
        send(16'h0000); pwm_a = 1'b1; tick(4);
        chk("R4 pwm_a", {8'h0, drive}, 16'h0010);
        pwm_b = 1'b1; tick(4);
        chk("R4 pwm_a+pwm_b", {8'h0, drive}, 16'h0030);
        pwm_a = 1'b0; pwm_b = 1'b0; send(16'h0010); tick(4);
        chk("R4 command alone", {8'h0, drive}, 16'h0010);

        // R10 then R8: latency and overvoltage recovery
        send(16'h770F); tick(4);
        @(negedge clk); ov = 1'b1;
        tick(2);
        chk("R10 not yet", {8'h0, drive}, 16'h000F);
        tick(1);
        chk("R10/R8 off at third edge", {8'h0, drive}, 16'h0000);
        chk("R8 detect kept", {8'h0, detect}, 16'h0077);
        ov = 1'b0; tick(4);
        chk("R8 restored", {8'h0, drive}, 16'h000F);

        // R9: per-output thermal
        ot = 8'h02; tick(4);
        chk("R9 one off", {8'h0, drive}, 16'h000D);
        ot = 8'h00; tick(4);
        chk("R9 auto restart", {8'h0, drive}, 16'h000F);
        ot = 8'h04; tick(4);
        send(16'h000B);
        ot = 8'h00; tick(4);
        chk("R9 no restart after clear", {8'h0, drive}, 16'h000B);

        // R6: enable low then re-enable
        send(16'hFFFF); tick(4);
        en = 1'b0; tick(4);
        chk("R6 en low drive", {8'h0, drive}, 16'h0000);
        chk("R6 en low detect", {8'h0, detect}, 16'h0000);
        en = 1'b1; tick(POR + 6);
        chk("R6 cleared after wake", {drive, detect}, 16'h0000);
        send(16'h00F0); tick(4);
        vdd_ok = 1'b0; tick(4);
        chk("R6 supply absent", {8'h0, drive}, 16'h0000);
        vdd_ok = 1'b1; tick(POR + 6);
        chk("R6 cleared after supply", {8'h0, drive}, 16'h0000);

        // R7: undervoltage
        send(16'h3333); tick(4);
        uv = 1'b1; tick(4);
        chk("R7 off", {drive, detect}, 16'h0000);
        chk("R7 busy", {15'h0, busy}, 16'h1);
        uv = 1'b0; tick(POR + 6);
        chk("R7 cleared", {drive, detect}, 16'h0000);

        // R2/R3/R4/R8/R9: random patterns
        for (int k = 0; k < 300; k++) begin
            logic [15:0] w;
            logic [7:0]  h;
            logic        pa, pb, o;
            w  = 16'($urandom);
            h  = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
            pa = 1'($urandom);
            pb = 1'($urandom);
            o  = ($urandom % 4 == 0);
            pwm_a = pa; pwm_b = pb; ot = h; ov = o;
            send(w); tick(4);
            chk("R2 random drive", {8'h0, drive}, {8'h0, model_drive(w[7:0], pa, pb, h, o)});
            chk("R3 random detect", {8'h0, detect}, {8'h0, w[15:8]});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule